// File: doc/BRIEF.md
# SPI Master Register Unit

This unit is the register and queue front end of an SPI master. A host reaches it over a simple 32-bit bus with word-aligned addresses. Reads are combinational in the cycle the host selects them. Side effects of an access, such as a pop or a flag clear, take place at the next rising clock edge.

The unit holds the following state:
- the serial configuration: frame size, frame format, clock phase and polarity, transfer mode, receive frame count and baud divider;
- a global enable;
- a slave-select mask;
- two FIFO watermark settings;
- an interrupt mask.

It also holds one transmit FIFO and one receive FIFO. A separate serial engine drains the transmit FIFO, fills the receive FIFO and reports whether it is busy.

Software loads outgoing frames by writing the data port and collects incoming frames by reading the same port. Clearing the enable stops the engine and throws away everything queued in both directions. The serial configuration is locked while the enable is set. The transmit watermark clips to the largest value the FIFO depth allows, so software can find the depth by writing increasing values until the readback no longer matches.

Top module: `spim_csr`

## Requirements
- R1: After reset the enable reads 0, the interrupt mask reads 0x3F, both FIFO levels read 0 and the status word reads 0x06.
- R2: Writes to the control word (word 0x00), receive frame count (0x04) and baud divider (0x14) are ignored while the enable (0x08, bit 0) is 1. They take effect while it is 0. The control fields are frame size minus one in bits 3:0, format in 5:4, phase in 6, polarity in 7 and mode in 9:8.
- R3: The TX watermark (0x18) and RX watermark (0x1C) store min(written value, DEPTH-1). Probing with increasing writes first mismatches at the value DEPTH.
- R4: Each write to the data port (0x60) appends one TX entry. The engine sees the entries in write order, and the TX level (0x20) tracks the occupancy.
- R5: Each read of the data port returns the oldest RX entry and removes it, and the RX level (0x24) tracks the occupancy. A read of an empty RX FIFO returns 0 and changes nothing.
- R6: The status word (0x28) has these bits: bit0 engine busy, bit1 TX not full, bit2 TX empty, bit3 RX not empty, bit4 RX full, bit5 transmit error, bit6 collision. Bit 6 always reads 0.
- R7: A data-port write while the TX FIFO is full and the engine is not popping is dropped, and it sets the transmit error flag. The status read that returns the flag clears it.
- R8: Writing 0 to the enable empties both FIFOs at the next edge.
- R9: An engine push that lands in the same cycle as a flush is lost. A push and a pop in the same cycle on a full RX FIFO leave it full and return the oldest entry.
- R10: The slave-select mask (0x10) is writable at any time and drives the select-mask output directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_tx_valid | output | 1 | TX FIFO holds an entry |
| eng_tx_data | output | DW | Oldest TX entry |
| eng_tx_pop | input | 1 | Engine consumes the TX entry |
| eng_rx_push | input | 1 | Engine delivers an RX entry |
| eng_rx_data | input | DW | Received frame |
| eng_busy | input | 1 | Engine is shifting |
| cfg_enable | output | 1 | Global enable |
| cfg_frame_bits | output | 4 | Frame size minus one |
| cfg_format | output | 2 | Frame format |
| cfg_cpha | output | 1 | Clock phase |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_tmode | output | 2 | Transfer mode |
| cfg_rx_frames | output | 16 | Receive frame count |
| cfg_baud_div | output | 16 | Baud divider |
| cfg_ss_mask | output | SS_W | Slave-select mask |

## Verification
Two events can fall into one cycle. In the first, the engine pushes into a full RX FIFO while the host pops it through the data port. The bench drives both strobes on the same edge and checks that the level stays at DEPTH and that the host received the oldest entry. In the second, the engine pushes in the same cycle that the host writes 0 to the enable. The bench drives both on the same edge and checks that the RX level reads 0 afterwards, so the flush wins.

// File: rtl/spim_csr_pkg.sv
package spim_csr_pkg;

    // word indices (byte address bits 7:2)
    localparam logic [5:0] IDX_CTRL   = 6'h00;
    localparam logic [5:0] IDX_FRAMES = 6'h01;
    localparam logic [5:0] IDX_EN     = 6'h02;
    localparam logic [5:0] IDX_SS     = 6'h04;
    localparam logic [5:0] IDX_BAUD   = 6'h05;
    localparam logic [5:0] IDX_TXTH   = 6'h06;
    localparam logic [5:0] IDX_RXTH   = 6'h07;
    localparam logic [5:0] IDX_TXLV   = 6'h08;
    localparam logic [5:0] IDX_RXLV   = 6'h09;
    localparam logic [5:0] IDX_STAT   = 6'h0A;
    localparam logic [5:0] IDX_IMASK  = 6'h0B;
    localparam logic [5:0] IDX_DATA   = 6'h18;

    localparam int IMASK_W = 6;

    // serial configuration word, bit 0 is the LSB of fsize
    typedef struct packed {
        logic [1:0] tmode;
        logic       cpol;
        logic       cpha;
        logic [1:0] fmt;
        logic [3:0] fsize;
    } ctrl_t;

    // status word, busy is bit 0
    typedef struct packed {
        logic dcol;
        logic tx_err;
        logic rx_full;
        logic rx_nempty;
        logic tx_empty;
        logic tx_nfull;
        logic busy;
    } stat_t;

    function automatic logic [31:0] clip_to(input logic [31:0] v, input logic [31:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [LVL_W-1:0] cnt;
    logic             push_ok, pop_ok;

    assign full    = (cnt == LVL_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign rdata   = mem[rp];
    assign level   = cnt;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush && !rst)
            mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= step(wp);
            if (pop_ok)  rp <= step(rp);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= LVL_W'(DEPTH)) else $error("level above depth"); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty) else $error("flush left entries"); // R8
    AST_FULL_PUSH_POP: assert property (@(posedge clk) disable iff (rst)
        (push && pop && full && !flush) |=> full) else $error("push+pop on full lost level"); // R9

endmodule

// File: rtl/spim_status.sv
module spim_status
    import spim_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy,
    input  logic  tx_full,
    input  logic  tx_empty,
    input  logic  rx_full,
    input  logic  rx_empty,
    input  logic  ovf_set,
    input  logic  err_clr,
    output stat_t stat
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst)          err_q <= 1'b0;
        else if (ovf_set) err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    always_comb begin
        stat.dcol      = 1'b0;
        stat.tx_err    = err_q;
        stat.rx_full   = rx_full;
        stat.rx_nempty = !rx_empty;
        stat.tx_empty  = tx_empty;
        stat.tx_nfull  = !tx_full;
        stat.busy      = busy;
    end

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> err_q) else $error("overflow not flagged"); // R7
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !ovf_set) |=> !err_q) else $error("flag survived status read"); // R7
    AST_TX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty)) else $error("tx full and empty"); // R6

endmodule

// File: rtl/spim_csr.sv
module spim_csr
    import spim_csr_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    parameter int SS_W  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            eng_tx_valid,
    output logic [DW-1:0]   eng_tx_data,
    input  logic            eng_tx_pop,
    input  logic            eng_rx_push,
    input  logic [DW-1:0]   eng_rx_data,
    input  logic            eng_busy,
    output logic            cfg_enable,
    output logic [3:0]      cfg_frame_bits,
    output logic [1:0]      cfg_format,
    output logic            cfg_cpha,
    output logic            cfg_cpol,
    output logic [1:0]      cfg_tmode,
    output logic [15:0]     cfg_rx_frames,
    output logic [15:0]     cfg_baud_div,
    output logic [SS_W-1:0] cfg_ss_mask
);
    localparam logic [31:0] THR_MAX = 32'(DEPTH - 1);

    ctrl_t              ctrl_q;
    logic [15:0]        frames_q, baud_q;
    logic               en_q;
    logic [SS_W-1:0]    ss_q;
    logic [PTR_W-1:0]   txth_q, rxth_q;
    logic [IMASK_W-1:0] imask_q;

    logic [5:0] idx;
    logic       wr_any, rd_any, cfg_open;
    logic       flush, dat_wr, dat_rd, stat_rd, tx_drop;
    logic [DW-1:0]    tx_head, rx_head;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic tx_full, tx_empty, rx_full, rx_empty;
    stat_t stat;
    logic [1:0] unused_addr_bits;

    assign unused_addr_bits = bus_addr[1:0];
    assign idx      = bus_addr[7:2];
    assign wr_any   = bus_sel && bus_wr;
    assign rd_any   = bus_sel && !bus_wr;
    assign cfg_open = !en_q;
    assign flush    = wr_any && (idx == IDX_EN) && !bus_wdata[0];
    assign dat_wr   = wr_any && (idx == IDX_DATA);
    assign dat_rd   = rd_any && (idx == IDX_DATA);
    assign stat_rd  = rd_any && (idx == IDX_STAT);
    assign tx_drop  = dat_wr && tx_full && !eng_tx_pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            frames_q <= '0;
            baud_q   <= '0;
            en_q     <= 1'b0;
            ss_q     <= '0;
            txth_q   <= '0;
            rxth_q   <= '0;
            imask_q  <= '1;
        end else if (wr_any) begin
            case (idx)
                IDX_CTRL:   if (cfg_open) ctrl_q   <= ctrl_t'(bus_wdata[9:0]);
                IDX_FRAMES: if (cfg_open) frames_q <= bus_wdata[15:0];
                IDX_BAUD:   if (cfg_open) baud_q   <= bus_wdata[15:0];
                IDX_EN:     en_q    <= bus_wdata[0];
                IDX_SS:     ss_q    <= bus_wdata[SS_W-1:0];
                IDX_TXTH:   txth_q  <= PTR_W'(clip_to(bus_wdata, THR_MAX));
                IDX_RXTH:   rxth_q  <= PTR_W'(clip_to(bus_wdata, THR_MAX));
                IDX_IMASK:  imask_q <= bus_wdata[IMASK_W-1:0];
                default: ;
            endcase
        end
    end

    spim_fifo #(.DEPTH(DEPTH), .W(DW)) u_txq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(dat_wr), .wdata(bus_wdata[DW-1:0]),
        .pop(eng_tx_pop), .rdata(tx_head),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.DEPTH(DEPTH), .W(DW)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(dat_rd), .rdata(rx_head),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    spim_status u_stat (
        .clk(clk), .rst(rst), .busy(eng_busy),
        .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty),
        .ovf_set(tx_drop), .err_clr(stat_rd), .stat(stat)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            case (idx)
                IDX_CTRL:   bus_rdata = 32'(ctrl_q);
                IDX_FRAMES: bus_rdata = 32'(frames_q);
                IDX_EN:     bus_rdata = 32'(en_q);
                IDX_SS:     bus_rdata = 32'(ss_q);
                IDX_BAUD:   bus_rdata = 32'(baud_q);
                IDX_TXTH:   bus_rdata = 32'(txth_q);
                IDX_RXTH:   bus_rdata = 32'(rxth_q);
                IDX_TXLV:   bus_rdata = 32'(tx_lvl);
                IDX_RXLV:   bus_rdata = 32'(rx_lvl);
                IDX_STAT:   bus_rdata = 32'(stat);
                IDX_IMASK:  bus_rdata = 32'(imask_q);
                IDX_DATA:   bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign eng_tx_valid   = !tx_empty;
    assign eng_tx_data    = tx_head;
    assign cfg_enable     = en_q;
    assign cfg_frame_bits = ctrl_q.fsize;
    assign cfg_format     = ctrl_q.fmt;
    assign cfg_cpha       = ctrl_q.cpha;
    assign cfg_cpol       = ctrl_q.cpol;
    assign cfg_tmode      = ctrl_q.tmode;
    assign cfg_rx_frames  = frames_q;
    assign cfg_baud_div   = baud_q;
    assign cfg_ss_mask    = ss_q;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        en_q |=> ($stable(ctrl_q) && $stable(frames_q) && $stable(baud_q)))
        else $error("config changed while enabled"); // R2
    AST_THR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (32'(txth_q) <= THR_MAX) && (32'(rxth_q) <= THR_MAX))
        else $error("watermark out of range"); // R3
    AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        tx_drop |=> (tx_lvl == LVL_W'(DEPTH))) else $error("dropped write changed level"); // R7

endmodule

// File: tb/spim_csr_test.sv
`timescale 1ns/1ps
module spim_csr_test;
    localparam int DEPTH = 8;
    localparam int DW    = 16;
    localparam int SS_W  = 4;

    localparam logic [7:0] A_CTRL = 8'h00, A_FRM = 8'h04, A_EN = 8'h08, A_SS = 8'h10,
                           A_BAUD = 8'h14, A_TXTH = 8'h18, A_RXTH = 8'h1C, A_TXLV = 8'h20,
                           A_RXLV = 8'h24, A_STAT = 8'h28, A_IMSK = 8'h2C, A_DATA = 8'h60;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_sel = 0, bus_wr = 0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic eng_tx_valid, eng_tx_pop = 0, eng_rx_push = 0, eng_busy = 0;
    logic [DW-1:0] eng_tx_data, eng_rx_data = '0;
    logic cfg_enable, cfg_cpha, cfg_cpol;
    logic [3:0] cfg_frame_bits;
    logic [1:0] cfg_format, cfg_tmode;
    logic [15:0] cfg_rx_frames, cfg_baud_div;
    logic [SS_W-1:0] cfg_ss_mask;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    spim_csr #(.DEPTH(DEPTH), .DW(DW), .SS_W(SS_W)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .cfg_enable(cfg_enable),
        .cfg_frame_bits(cfg_frame_bits), .cfg_format(cfg_format), .cfg_cpha(cfg_cpha),
        .cfg_cpol(cfg_cpol), .cfg_tmode(cfg_tmode), .cfg_rx_frames(cfg_rx_frames),
        .cfg_baud_div(cfg_baud_div), .cfg_ss_mask(cfg_ss_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic eng_push(input logic [DW-1:0] d);
        @(negedge clk);
        eng_rx_push = 1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 0;
    endtask

    task automatic eng_pop();
        @(negedge clk);
        eng_tx_pop = 1;
        @(negedge clk);
        eng_tx_pop = 0;
    endtask

    task automatic t_reset();
        rchk("R1 enable", A_EN, 0);
        rchk("R1 imask", A_IMSK, 32'h3F);
        rchk("R1 txlvl", A_TXLV, 0);
        rchk("R1 rxlvl", A_RXLV, 0);
        rchk("R1 status", A_STAT, 32'h06);
    endtask

    task automatic t_cfg_lock();
        wr(A_CTRL, 32'h2C7); wr(A_FRM, 32'h0123); wr(A_BAUD, 32'h0010);
        rchk("R2 ctrl open", A_CTRL, 32'h2C7);
        chk("R2 fields", {cfg_tmode, cfg_cpol, cfg_cpha, cfg_format, cfg_frame_bits}, 32'h2C7);
        wr(A_EN, 1);
        chk("R2 enable out", cfg_enable, 1);
        wr(A_CTRL, 0); wr(A_FRM, 5); wr(A_BAUD, 2);
        rchk("R2 ctrl locked", A_CTRL, 32'h2C7);
        rchk("R2 frames locked", A_FRM, 32'h0123);
        chk("R2 baud locked", cfg_baud_div, 16'h0010);
        wr(A_EN, 0);
        wr(A_BAUD, 2);
        rchk("R2 baud open", A_BAUD, 2);
    endtask

    task automatic t_thr();
        int found = 0;
        logic [31:0] v;
        wr(A_TXTH, 3);   rchk("R3 tx mid", A_TXTH, 3);
        wr(A_TXTH, 200); rchk("R3 tx clip", A_TXTH, DEPTH - 1);
        wr(A_RXTH, 9);   rchk("R3 rx clip", A_RXTH, DEPTH - 1);
        for (int k = 1; k < 256; k++) begin
            wr(A_TXTH, k);
            rd(A_TXTH, v);
            if (v != k) begin found = k; break; end
        end
        chk("R3 probe depth", found, DEPTH);
        wr(A_TXTH, 0);
    endtask

    task automatic t_ss();
        wr(A_EN, 1);
        wr(A_SS, 5);
        chk("R10 ss out", cfg_ss_mask, 5);
        rchk("R10 ss read", A_SS, 5);
        wr(A_EN, 0);
    endtask

    task automatic t_tx_order();
        wr(A_DATA, 16'hA1); wr(A_DATA, 16'hB2); wr(A_DATA, 16'hC3);
        rchk("R4 txlvl", A_TXLV, 3);
        chk("R4 valid", eng_tx_valid, 1);
        chk("R4 head0", eng_tx_data, 16'hA1);
        eng_pop();
        chk("R4 head1", eng_tx_data, 16'hB2);
        eng_pop();
        chk("R4 head2", eng_tx_data, 16'hC3);
        eng_pop();
        chk("R4 drained", eng_tx_valid, 0);
        rchk("R6 tx empty status", A_STAT, 32'h06);
    endtask

    task automatic t_tx_full();
        for (int i = 0; i < DEPTH; i++) wr(A_DATA, 32'(i + 16'h40));
        rchk("R6 tx full status", A_STAT, 32'h00);
        wr(A_DATA, 16'hEE);
        rchk("R7 level kept", A_TXLV, DEPTH);
        rchk("R7 err set", A_STAT, 32'h20);
        rchk("R7 err cleared", A_STAT, 32'h00);
        chk("R7 head kept", eng_tx_data, 16'h40);
    endtask

    task automatic t_rx();
        eng_push(16'h11); eng_push(16'h22); eng_push(16'h33);
        rchk("R5 rxlvl", A_RXLV, 3);
        rchk("R5 pop0", A_DATA, 16'h11);
        rchk("R5 pop1", A_DATA, 16'h22);
        rchk("R5 pop2", A_DATA, 16'h33);
        rchk("R5 empty read", A_DATA, 0);
        rchk("R5 level zero", A_RXLV, 0);
        eng_busy = 1;
        rchk("R6 busy", A_STAT, 32'h07);
        eng_busy = 0;
    endtask

    task automatic t_flush();
        wr(A_DATA, 16'h5); eng_push(16'h6);
        wr(A_EN, 0);
        rchk("R8 tx flushed", A_TXLV, 0);
        rchk("R8 rx flushed", A_RXLV, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        for (int i = 0; i < DEPTH; i++) eng_push(16'(16'h80 + i));
        rchk("R6 rx full status", A_STAT, 32'h1E);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = A_DATA;
        eng_rx_push = 1; eng_rx_data = 16'h99;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_sel = 0; eng_rx_push = 0;
        chk("R9 oldest popped", v, 16'h80);
        rchk("R9 still full", A_RXLV, DEPTH);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = A_EN; bus_wdata = 0;
        eng_rx_push = 1; eng_rx_data = 16'h77;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; eng_rx_push = 0;
        rchk("R9 flush wins", A_RXLV, 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_cfg_lock();
        t_thr();
        t_ss();
        t_tx_order();
        t_tx_full();
        wr(A_EN, 0);
        t_rx();
        t_flush();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule